// File: doc/BRIEF.md
# Error Severity Escalation Controller

This controller collects error events from across a system and turns them into exactly one recovery action per accepted event. The actions, from least to most severe, are a processor interrupt, a processor reset, a system reset and a request to reload the device configuration. Each event source maps to a fixed severity tier. When several sources fire together, the most severe tier decides the action.

Two saturating counters record how many processor resets and system resets have been issued. When a tier's counter is already full, a further event of that tier moves up to the next tier. Repeated faults therefore push the recovery up without any software involvement. After a processor or system reset, a programmable holdoff masks follow-on events of equal or lower severity. This stops the disturbance caused by the reset itself from triggering another one. A reconfiguration request is held until the reload logic acknowledges it. The controller then goes back to monitoring.

Top module: `err_escalate`

## Requirements
- R1: If any bit of `mem_sbe` is sampled high and nothing more severe is present, `cpu_irq` is high for exactly the following cycle.
- R2: `cpu_mismatch`, `cpu_wdog` or `ocm_dbe` produces a one-cycle `cpu_rst` pulse in the following cycle and increments `cpu_rst_cnt` at the same time.
- R3: Either bit of `bus_err` produces a one-cycle `sys_rst` pulse in the following cycle and increments `sys_rst_cnt` at the same time.
- R4: `cfg_fail`, `busmem_dbe` or `dram_dbe` raises `reconf_req` in the following cycle. It stays high until an edge samples `reconf_ack` high and is low in the cycle after that edge.
- R5: Severity order is interrupt < processor reset < system reset < reconfiguration. Simultaneous events yield only the most severe action, so at most one of `cpu_irq`, `cpu_rst`, `sys_rst` is high, and none is high in a cycle where `reconf_req` rises.
- R6: A processor-reset-tier event that arrives while `cpu_rst_cnt` is 7 issues `sys_rst` instead of `cpu_rst`. `cpu_rst_cnt` stays at 7 and `sys_rst_cnt` increments.
- R7: A system-reset-tier event, including one escalated under R6, that arrives while `sys_rst_cnt` is 7 raises `reconf_req` instead of `sys_rst`.
- R8: Both counters are 3 bits wide and never exceed 7. They read 0 in the cycle after an edge where `clr_counts` is high, and in the cycle where `reconf_req` rises.
- R9: After a `cpu_rst` or `sys_rst` action with `holdoff` = H > 0, the next H edges ignore events whose resulting action is not more severe than that reset. A more severe event is accepted and restarts the holdoff at its own level.
- R10: After reset all outputs are 0 and the controller is monitoring.
- R11: While `reconf_req` is high, all events are ignored: no pulse is issued and the counters do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_sbe | input | 3 | Single-bit error flags from the three protected memories |
| cpu_mismatch | input | 1 | Lockstep processor disagreement |
| cpu_wdog | input | 1 | Processor watchdog expiry |
| ocm_dbe | input | 1 | Double-bit error in processor-local memory |
| bus_err | input | 2 | Bus errors: bit 0 processor bus, bit 1 peripheral bus |
| cfg_fail | input | 1 | Configuration integrity check failed |
| busmem_dbe | input | 1 | Double-bit error in bus-attached memory |
| dram_dbe | input | 1 | Double-bit error in external DRAM |
| reconf_ack | input | 1 | Reload logic has taken the reconfiguration request |
| clr_counts | input | 1 | Clears both reset counters |
| holdoff | input | 8 | Holdoff length in cycles after a reset action |
| cpu_irq | output | 1 | Interrupt pulse |
| cpu_rst | output | 1 | Processor reset pulse |
| sys_rst | output | 1 | System reset pulse |
| reconf_req | output | 1 | Held reconfiguration request |
| cpu_rst_cnt | output | 3 | Processor reset counter |
| sys_rst_cnt | output | 3 | System reset counter |

## Verification
Every action and counter update is registered. It is therefore visible in the cycle after the rising edge that samples the event. `reconf_req` falls in the cycle after the edge that sees `reconf_ack`. A holdoff of H masks exactly the H edges that follow the action, and the event on the next edge is accepted. The bench changes inputs on the falling edge and compares every output on the following falling edge against a behavioural model that is stepped on the rising edge in between. The directed checks use the same falling-edge sampling, one edge after the stimulus.

// File: rtl/err_escalate.sv
module err_escalate #(
  parameter int CNT_W  = 3,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mem_sbe,
  input  logic              cpu_mismatch,
  input  logic              cpu_wdog,
  input  logic              ocm_dbe,
  input  logic [1:0]        bus_err,
  input  logic              cfg_fail,
  input  logic              busmem_dbe,
  input  logic              dram_dbe,
  input  logic              reconf_ack,
  input  logic              clr_counts,
  input  logic [HOLD_W-1:0] holdoff,
  output logic              cpu_irq,
  output logic              cpu_rst,
  output logic              sys_rst,
  output logic              reconf_req,
  output logic [CNT_W-1:0]  cpu_rst_cnt,
  output logic [CNT_W-1:0]  sys_rst_cnt
);

  localparam logic [CNT_W-1:0] CNT_FULL = '1;

  typedef enum logic [2:0] {LV_NONE, LV_IRQ, LV_CPU, LV_SYS, LV_CFG} lvl_t;
  typedef enum logic [1:0] {ST_MON, ST_HOLD, ST_RECONF} st_t;

  st_t              st;
  lvl_t             hold_lvl;
  logic [HOLD_W-1:0] hold_cnt;
  lvl_t             raw, esc, act, take;

  wire cpu_full = (cpu_rst_cnt == CNT_FULL);
  wire sys_full = (sys_rst_cnt == CNT_FULL);

  always_comb begin
    if (cfg_fail | busmem_dbe | dram_dbe)             raw = LV_CFG;
    else if (|bus_err)                                raw = LV_SYS;
    else if (cpu_mismatch | cpu_wdog | ocm_dbe)       raw = LV_CPU;
    else if (|mem_sbe)                                raw = LV_IRQ;
    else                                              raw = LV_NONE;

    esc = raw;
    if (raw == LV_CPU && cpu_full) esc = LV_SYS;
    act = esc;
    if (esc == LV_SYS && sys_full) act = LV_CFG;

    take = act;
    if (st == ST_RECONF)                          take = LV_NONE;
    else if (st == ST_HOLD && act <= hold_lvl)    take = LV_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_MON;
      hold_lvl    <= LV_NONE;
      hold_cnt    <= '0;
      cpu_irq     <= 1'b0;
      cpu_rst     <= 1'b0;
      sys_rst     <= 1'b0;
      reconf_req  <= 1'b0;
      cpu_rst_cnt <= '0;
      sys_rst_cnt <= '0;
    end else begin
      cpu_irq <= (take == LV_IRQ);
      cpu_rst <= (take == LV_CPU);
      sys_rst <= (take == LV_SYS);

      if (clr_counts || take == LV_CFG) begin
        cpu_rst_cnt <= '0;
        sys_rst_cnt <= '0;
      end else begin
        if (take == LV_CPU) cpu_rst_cnt <= cpu_rst_cnt + 1'b1;
        if (take == LV_SYS) sys_rst_cnt <= sys_rst_cnt + 1'b1;
      end

      if (st == ST_RECONF) begin
        if (reconf_ack) begin
          reconf_req <= 1'b0;
          st         <= ST_MON;
        end
      end else if (take == LV_CFG) begin
        reconf_req <= 1'b1;
        hold_cnt   <= '0;
        st         <= ST_RECONF;
      end else if (take == LV_CPU || take == LV_SYS) begin
        hold_lvl <= take;
        hold_cnt <= holdoff;
        if (holdoff != '0) st <= ST_HOLD;
        else               st <= ST_MON;
      end else if (st == ST_HOLD) begin
        hold_cnt <= hold_cnt - 1'b1;
        if (hold_cnt == 1) st <= ST_MON;
      end
    end
  end

endmodule

// File: rtl/err_escalate_chk.sv
module err_escalate_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mem_sbe,
  input logic             cpu_mismatch,
  input logic             cpu_wdog,
  input logic             ocm_dbe,
  input logic [1:0]       bus_err,
  input logic             reconf_ack,
  input logic             clr_counts,
  input logic             cpu_irq,
  input logic             cpu_rst,
  input logic             sys_rst,
  input logic             reconf_req,
  input logic [CNT_W-1:0] cpu_rst_cnt,
  input logic [CNT_W-1:0] sys_rst_cnt
);

  a_r1_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> $past(|mem_sbe));

  a_r2_cpu_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst |-> $past(cpu_mismatch | cpu_wdog | ocm_dbe));

  a_r3_sys_cause: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> $past((|bus_err) | cpu_mismatch | cpu_wdog | ocm_dbe));

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (reconf_req && !reconf_ack) |=> reconf_req);

  a_r4_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (reconf_req && reconf_ack) |=> !reconf_req);

  a_r5_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_irq, cpu_rst, sys_rst, $rose(reconf_req)}));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_counts |=> (cpu_rst_cnt == '0 && sys_rst_cnt == '0));

  a_r8_reconf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reconf_req) |-> (cpu_rst_cnt == '0 && sys_rst_cnt == '0));

  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_req |=> (!cpu_irq && !cpu_rst && !sys_rst));

endmodule

bind err_escalate err_escalate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_sbe(mem_sbe), .cpu_mismatch(cpu_mismatch),
  .cpu_wdog(cpu_wdog), .ocm_dbe(ocm_dbe), .bus_err(bus_err),
  .reconf_ack(reconf_ack), .clr_counts(clr_counts), .cpu_irq(cpu_irq),
  .cpu_rst(cpu_rst), .sys_rst(sys_rst), .reconf_req(reconf_req),
  .cpu_rst_cnt(cpu_rst_cnt), .sys_rst_cnt(sys_rst_cnt)
);

// File: tb/err_escalate_test.sv
`timescale 1ns/1ps
module err_escalate_test;
  logic clk = 0, rst_n = 0;
  logic [2:0] mem_sbe = 0;
  logic cpu_mismatch = 0, cpu_wdog = 0, ocm_dbe = 0;
  logic [1:0] bus_err = 0;
  logic cfg_fail = 0, busmem_dbe = 0, dram_dbe = 0;
  logic reconf_ack = 0, clr_counts = 0;
  logic [7:0] holdoff = 0;
  logic cpu_irq, cpu_rst, sys_rst, reconf_req;
  logic [2:0] cpu_rst_cnt, sys_rst_cnt;

  err_escalate uut (.*);

  always #4 clk = ~clk;

  localparam logic [10:0] E_SBE0 = 11'h001, E_SBE2 = 11'h004, E_MIS = 11'h008,
    E_WDG = 11'h010, E_OCM = 11'h020, E_BUSP = 11'h040, E_BUSO = 11'h080,
    E_DRAM = 11'h100, E_BMEM = 11'h200, E_CFG = 11'h400;

  int total = 0, fails = 0;
  bit done = 0;

  // behavioural reference
  int m_cpu, m_sys, m_hold, m_hlvl, m_rec;
  int x_irq, x_cpu, x_sys, x_req;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cpu = 0; m_sys = 0; m_hold = 0; m_hlvl = 0; m_rec = 0;
      x_irq = 0; x_cpu = 0; x_sys = 0; x_req = 0;
    end else begin
      int lvl;
      lvl = 0;
      if (|mem_sbe) lvl = 1;
      if (cpu_mismatch || cpu_wdog || ocm_dbe) lvl = 2;
      if (|bus_err) lvl = 3;
      if (cfg_fail || busmem_dbe || dram_dbe) lvl = 4;
      if (lvl == 2 && m_cpu == 7) lvl = 3;
      if (lvl == 3 && m_sys == 7) lvl = 4;
      if (m_rec != 0) lvl = 0;
      else if (m_hold > 0 && lvl <= m_hlvl) lvl = 0;
      x_irq = (lvl == 1); x_cpu = (lvl == 2); x_sys = (lvl == 3);
      if (m_rec != 0) begin
        if (reconf_ack) begin m_rec = 0; x_req = 0; end
      end else if (lvl == 4) begin
        m_rec = 1; x_req = 1; m_hold = 0;
      end else if (lvl == 2 || lvl == 3) begin
        m_hlvl = lvl; m_hold = holdoff;
      end else if (m_hold > 0) m_hold--;
      if (clr_counts || lvl == 4) begin m_cpu = 0; m_sys = 0; end
      else begin
        if (lvl == 2) m_cpu++;
        if (lvl == 3) m_sys++;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    total++;
    if ({cpu_irq, cpu_rst, sys_rst, reconf_req} !== {x_irq[0], x_cpu[0], x_sys[0], x_req[0]} ||
        cpu_rst_cnt !== m_cpu[2:0] || sys_rst_cnt !== m_sys[2:0]) begin
      fails++;
      $display("FAIL model(R1..R11 per cycle): got irq%0b cpu%0b sys%0b req%0b c%0d s%0d exp irq%0d cpu%0d sys%0d req%0d c%0d s%0d",
        cpu_irq, cpu_rst, sys_rst, reconf_req, cpu_rst_cnt, sys_rst_cnt,
        x_irq, x_cpu, x_sys, x_req, m_cpu, m_sys);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ev(input logic [10:0] e);
    {cfg_fail, busmem_dbe, dram_dbe, bus_err, ocm_dbe, cpu_wdog, cpu_mismatch, mem_sbe} = e;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic fire(input logic [10:0] e);
    ev(e); tick(); ev(0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    chk("R10 outputs", {cpu_irq, cpu_rst, sys_rst, reconf_req}, 0);
    chk("R10 counts", {cpu_rst_cnt, sys_rst_cnt}, 0);

    fire(E_SBE2);
    chk("R1 irq pulse", cpu_irq, 1);
    tick();
    chk("R1 irq one cycle", cpu_irq, 0);

    fire(E_MIS); chk("R2 cpu_rst", cpu_rst, 1); chk("R2 cnt", cpu_rst_cnt, 1);
    fire(E_WDG); fire(E_OCM); chk("R2 cnt 3", cpu_rst_cnt, 3);
    tick(); chk("R2 pulse ends", cpu_rst, 0);

    fire(E_BUSP); chk("R3 sys_rst", sys_rst, 1); chk("R3 cnt", sys_rst_cnt, 1);
    fire(E_BUSO); chk("R3 cnt 2", sys_rst_cnt, 2);

    fire(E_SBE0 | E_MIS | E_BUSO);
    chk("R5 only sys", {cpu_irq, cpu_rst, sys_rst}, 3'b001);
    fire(E_SBE0 | E_WDG);
    chk("R5 cpu over irq", {cpu_irq, cpu_rst, sys_rst}, 3'b010);

    clr_counts = 1; tick(); clr_counts = 0;
    chk("R8 clear", {cpu_rst_cnt, sys_rst_cnt}, 0);

    for (int i = 0; i < 7; i++) fire(E_MIS);
    chk("R8 cpu at 7", cpu_rst_cnt, 7);
    fire(E_MIS);
    chk("R6 escalated", {cpu_rst, sys_rst}, 2'b01);
    chk("R6 cpu stays 7", cpu_rst_cnt, 7);
    chk("R6 sys inc", sys_rst_cnt, 1);

    for (int i = 0; i < 6; i++) fire(E_BUSP);
    chk("R8 sys at 7", sys_rst_cnt, 7);
    fire(E_BUSO);
    chk("R7 reconf", reconf_req, 1);
    chk("R7 no sys_rst", sys_rst, 0);
    chk("R8 reconf clears", {cpu_rst_cnt, sys_rst_cnt}, 0);

    fire(E_MIS | E_SBE0);
    chk("R11 ignored", {cpu_irq, cpu_rst}, 0);
    chk("R11 cnt", cpu_rst_cnt, 0);
    chk("R4 held", reconf_req, 1);
    reconf_ack = 1; tick(); reconf_ack = 0;
    chk("R4 drop after ack", reconf_req, 0);

    fire(E_DRAM); chk("R4 dram", reconf_req, 1);
    repeat (3) tick(); chk("R4 still held", reconf_req, 1);
    reconf_ack = 1; tick(); reconf_ack = 0;
    fire(E_BMEM); chk("R4 busmem", reconf_req, 1);
    reconf_ack = 1; tick(); reconf_ack = 0;
    fire(E_CFG); chk("R4 cfg", reconf_req, 1);
    reconf_ack = 1; tick(); reconf_ack = 0;

    holdoff = 3;
    ev(E_MIS); tick();
    chk("R9 first accepted", cpu_rst, 1);
    for (int i = 0; i < 3; i++) begin tick(); chk("R9 masked", cpu_rst, 0); end
    tick(); ev(0);
    chk("R9 after holdoff", cpu_rst, 1);
    chk("R9 cnt", cpu_rst_cnt, 2);
    fire(E_SBE0); chk("R9 irq masked", cpu_irq, 0);
    fire(E_BUSP); chk("R9 higher accepted", sys_rst, 1);
    fire(E_MIS); chk("R9 lower masked", cpu_rst, 0);
    repeat (5) tick();
    fire(E_WDG); chk("R9 released", cpu_rst, 1);
    holdoff = 0;
    repeat (4) tick();
    finish_run();
  end
endmodule